// File: doc/BRIEF.md
# Conditional Nonvolatile Store Controller

This block sequences the copy of an SRAM image into its nonvolatile shadow and the copy back after power returns. A store can be asked for in three ways: by the power sense going low, by any device pulling a shared active-low open-drain request/busy line, or by a one-cycle pulse from a software-sequence detector. A dirty flag records whether any write has been accepted since the last store or recall. Power-loss and line requests are dropped while the flag is clean. A software pulse always stores.

Each store has three phases: a grace window in which reads still complete and new writes are refused, an erase phase, and a program phase. The block pulls the shared line low from the start of the grace window to the end of programming. It then keeps the host locked out until it samples the line high again, so that other devices on the line can finish their own stores. A power-low indication latches a recall. When power comes back, the block runs a recall for a fixed time before it accepts host accesses. The nonvolatile array is modelled only by these fixed phase durations, all given as cycle-count parameters.

The host access port uses valid/ready. A transfer happens on a rising clock edge where `acc_valid` and `acc_ready` are both high. `acc_ready` may depend on `acc_we` in the same cycle, because reads and writes are gated differently. The host must hold its request until it sees ready, and a refused write is never recorded.

Top module: `nv_store_ctrl`

## Requirements
- R1: While reset is asserted and afterwards, as long as `pwr_low` is high, `busy_drive` is 0, `nv_op` is 0 and `acc_ready` is 0. Once `pwr_low` is low, `nv_op` reads 3 (recall) for exactly RECALL_CYC cycles, and after that `acc_ready` is 1 for reads.
- R2: With the dirty flag set and `inhibit_auto` low, `pwr_low` rising while the block is idle starts a store. With the flag clean, no store runs (`busy_drive` stays 0), and the block goes to the power-off state with `acc_ready` 0.
- R3: A low level on `busy_line_i` seen in idle starts a store only if the dirty flag is set. Otherwise `nv_op` stays 0 and `busy_drive` stays 0.
- R4: A one-cycle `sw_store` pulse in idle starts a store whether or not the dirty flag is set.
- R5: Every store begins with a grace window of DELAY_CYC cycles. In it `busy_drive` is 1 and `nv_op` is 0, `acc_ready` is 1 when `acc_we` is 0 and 0 when `acc_we` is 1.
- R6: In idle, once the line has been sampled low through the two-stage synchronizer, `acc_ready` is 0 for writes and 1 for reads. Writes are accepted again once the line has been sampled high.
- R7: After the grace window, `nv_op` reads 1 (erase) for exactly ERASE_CYC cycles and then 2 (program) for exactly PROG_CYC cycles. `busy_drive` is 1 through both phases and falls when programming ends.
- R8: During erase and program, `acc_ready` is 0.
- R9: After programming ends, `acc_ready` stays 0 and `busy_drive` stays 0 until `busy_line_i` has been sampled high.
- R10: With `inhibit_auto` high, `pwr_low` never starts a store. Stores started by the software pulse or by the line still run.
- R11: A `pwr_low` indication seen at any time during a store, even a brief one, makes the block run a recall after the store is released, once `pwr_low` is low.
- R12: The dirty flag is set by every accepted write and cleared when a store or recall completes. A line request with no write since then is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also latches a power-up recall |
| pwr_low | input | 1 | Supply below the switching threshold |
| inhibit_auto | input | 1 | 1 disables the store on power loss |
| sw_store | input | 1 | One-cycle pulse from the software-sequence detector |
| busy_line_i | input | 1 | Sampled level of the shared open-drain request/busy line (0 = pulled low) |
| busy_drive | output | 1 | 1 enables this block's pull-down on the shared line |
| acc_valid | input | 1 | Host access request valid |
| acc_we | input | 1 | Host access is a write (1) or a read (0) |
| acc_ready | output | 1 | Host access may complete this cycle |
| nv_op | output | 2 | Array operation: 0 none, 1 erase, 2 program, 3 recall |

## Verification
The case that matters is a software pulse and a power-low indication arriving in the same idle cycle while the dirty flag is clean. The power-low request alone would be dropped, but the pulse must still start a full store. The latched power loss must then send the block into power-off once the line is released, and a recall must follow when power returns. The bench raises both inputs at the same clock edge straight after a completed store has cleared the flag. It checks the phase lengths of that store, that the host stays locked out afterwards, and the length of the following recall.

// File: rtl/nvsc_pkg.sv
package nvsc_pkg;

  typedef enum logic [2:0] {
    ST_PWROFF  = 3'd0,
    ST_RECALL  = 3'd1,
    ST_IDLE    = 3'd2,
    ST_GRACE   = 3'd3,
    ST_ERASE   = 3'd4,
    ST_PROG    = 3'd5,
    ST_RELEASE = 3'd6
  } ctl_state_e;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_ERASE  = 2'd1,
    OP_PROG   = 2'd2,
    OP_RECALL = 2'd3
  } arr_op_e;

endpackage

// File: rtl/nvsc_sync.sv
module nvsc_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= RESET_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nvsc_timer.sv
module nvsc_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // Counter never underflows: a cycle after reaching zero without a load it stays zero
  assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);
endmodule

// File: rtl/nvsc_dirty.sv
module nvsc_dirty (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_fire,
  input  logic nv_done,
  output logic dirty
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dirty <= 1'b0;
    else if (wr_fire) dirty <= 1'b1;
    else if (nv_done) dirty <= 1'b0;
  end

  assert_write_marks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> dirty);
  assert_done_cleans_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_done && !wr_fire) |=> !dirty);
endmodule

// File: rtl/nv_store_ctrl.sv
module nv_store_ctrl
  import nvsc_pkg::*;
#(
  parameter int DELAY_CYC  = 8,
  parameter int ERASE_CYC  = 12,
  parameter int PROG_CYC   = 16,
  parameter int RECALL_CYC = 10,
  parameter int SYNC_STG   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_low,
  input  logic       inhibit_auto,
  input  logic       sw_store,
  input  logic       busy_line_i,
  output logic       busy_drive,
  input  logic       acc_valid,
  input  logic       acc_we,
  output logic       acc_ready,
  output logic [1:0] nv_op
);
  localparam int MAX_AB  = (DELAY_CYC > ERASE_CYC) ? DELAY_CYC : ERASE_CYC;
  localparam int MAX_CD  = (PROG_CYC > RECALL_CYC) ? PROG_CYC : RECALL_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] LD_DELAY  = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ERASE  = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PROG   = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RECALL = CNT_W'(RECALL_CYC - 1);

  ctl_state_e       state_q, state_d;
  logic             line_high_s, line_low_s;
  logic             dirty;
  logic             t_load, t_done;
  logic [CNT_W-1:0] t_val;
  logic             pwr_fail_q;
  logic             wr_fire, nv_done, store_go, auto_req;

  nvsc_sync #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) u_line_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (busy_line_i),
    .q_sync  (line_high_s)
  );
  assign line_low_s = !line_high_s;

  nvsc_timer #(.CNT_W(CNT_W)) u_phase_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_done)
  );

  nvsc_dirty u_dirty (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .nv_done (nv_done),
    .dirty   (dirty)
  );

  // Power loss seen at any time: remembered until the power-off state is entered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pwr_fail_q <= 1'b0;
    else if (state_q == ST_PWROFF) pwr_fail_q <= 1'b0;
    else if (pwr_low)             pwr_fail_q <= 1'b1;
  end

  assign auto_req = pwr_low && !inhibit_auto;
  assign store_go = sw_store || (dirty && (auto_req || line_low_s));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PWROFF:  if (!pwr_low) state_d = ST_RECALL;
      ST_RECALL: begin
        if (pwr_low)     state_d = ST_PWROFF;
        else if (t_done) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (store_go)     state_d = ST_GRACE;
        else if (pwr_low) state_d = ST_PWROFF;
      end
      ST_GRACE:   if (t_done) state_d = ST_ERASE;
      ST_ERASE:   if (t_done) state_d = ST_PROG;
      ST_PROG:    if (t_done) state_d = ST_RELEASE;
      ST_RELEASE: if (line_high_s)
                    state_d = (pwr_fail_q || pwr_low) ? ST_PWROFF : ST_IDLE;
      default:    state_d = ST_PWROFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PWROFF;
    else        state_q <= state_d;
  end

  always_comb begin
    t_load = (state_d != state_q);
    unique case (state_d)
      ST_GRACE:  t_val = LD_DELAY;
      ST_ERASE:  t_val = LD_ERASE;
      ST_PROG:   t_val = LD_PROG;
      ST_RECALL: t_val = LD_RECALL;
      default:   t_val = '0;
    endcase
  end

  assign nv_done = t_done && ((state_q == ST_PROG) || (state_q == ST_RECALL && !pwr_low));

  always_comb begin
    unique case (state_q)
      ST_IDLE:  acc_ready = !(acc_we && line_low_s);
      ST_GRACE: acc_ready = !acc_we;
      default:  acc_ready = 1'b0;
    endcase
  end

  assign wr_fire = acc_valid && acc_we && acc_ready;

  assign busy_drive = (state_q == ST_GRACE) || (state_q == ST_ERASE) || (state_q == ST_PROG);

  always_comb begin
    unique case (state_q)
      ST_ERASE:  nv_op = OP_ERASE;
      ST_PROG:   nv_op = OP_PROG;
      ST_RECALL: nv_op = OP_RECALL;
      default:   nv_op = OP_NONE;
    endcase
  end

  // ---------------- assertions ----------------
  assert_no_late_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && line_low_s) |-> !acc_ready);

  assert_store_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_GRACE) |-> ($past(sw_store) || $past(dirty)));

  assert_prog_after_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_op == OP_PROG) |-> ($past(nv_op) == OP_ERASE));

  assert_locked_in_array_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((nv_op == OP_ERASE) || (nv_op == OP_PROG)) |-> !acc_ready);

  assert_hold_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RELEASE && line_low_s) |=> (!acc_ready && !busy_drive));

  assert_inhibit_blocks_auto_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && inhibit_auto && !sw_store && line_high_s) |=> !busy_drive);
endmodule

// File: tb/tb_nv_store_ctrl.sv
`timescale 1ns/1ps
module tb_nv_store_ctrl;
  localparam int DLY = 8, ERS = 12, PRG = 16, RCL = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_low = 1'b1, inhibit_auto = 1'b0, sw_store = 1'b0;
  logic ext_pull = 1'b0;
  logic acc_valid = 1'b0, acc_we = 1'b0;
  logic busy_drive, acc_ready, busy_line;
  logic [1:0] nv_op;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  assign busy_line = !(busy_drive || ext_pull);

  nv_store_ctrl #(.DELAY_CYC(DLY), .ERASE_CYC(ERS), .PROG_CYC(PRG), .RECALL_CYC(RCL)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_low(pwr_low), .inhibit_auto(inhibit_auto),
    .sw_store(sw_store), .busy_line_i(busy_line), .busy_drive(busy_drive),
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_ready(acc_ready), .nv_op(nv_op));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Accepted write: held until ready, then released
  task automatic do_write();
    @(negedge clk);
    acc_valid = 1'b1; acc_we = 1'b1;
    #0.5;
    while (!acc_ready) @(negedge clk);
    @(negedge clk);
    acc_valid = 1'b0; acc_we = 1'b0;
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_store = 1'b1;
    @(negedge clk); sw_store = 1'b0;
  endtask

  // Wait for an op code, then count its run length
  task automatic op_run(input logic [1:0] op, output int len);
    int w = 0;
    len = 0;
    while (nv_op != op && w < 60) begin @(negedge clk); w++; end
    while (nv_op == op && len < 200) begin len++; @(negedge clk); end
  endtask

  // Measure one store; checks grace read/write gating and lockout in array phases
  task automatic measure_store(input string req, output bit seen);
    int w = 0, g = 0, e = 0, p = 0, bad = 0;
    seen = 1'b0;
    while (!busy_drive && w < 40) begin @(negedge clk); w++; end
    if (!busy_drive) return;
    seen = 1'b1;
    acc_we = 1'b0; #0.5;
    chk(acc_ready === 1'b1, "R5", "grace read ready", acc_ready, 1);
    acc_we = 1'b1; #0.5;
    chk(acc_ready === 1'b0, "R5", "grace write ready", acc_ready, 0);
    acc_we = 1'b0;
    while (busy_drive && (g + e + p) < 200) begin
      if (nv_op == 2'd0) g++;
      else if (nv_op == 2'd1) e++;
      else if (nv_op == 2'd2) p++;
      if (nv_op != 2'd0 && acc_ready) bad++;
      @(negedge clk);
    end
    chk(g == DLY, "R5", {req, " grace length"}, g, DLY);
    chk(e == ERS, "R7", {req, " erase length"}, e, ERS);
    chk(p == PRG, "R7", {req, " program length"}, p, PRG);
    chk(bad == 0, "R8", "ready during array phases", bad, 0);
  endtask

  task automatic wait_idle();
    int w = 0;
    while (!acc_ready && w < 40) begin @(negedge clk); w++; end
  endtask

  task automatic t_reset();
    int len;
    chk(busy_drive === 1'b0 && nv_op === 2'd0 && acc_ready === 1'b0, "R1", "in reset", {busy_drive, nv_op, acc_ready}, 0);
    cyc(3); rst_n = 1'b1; cyc(6);
    chk(nv_op === 2'd0 && acc_ready === 1'b0 && busy_drive === 1'b0, "R1", "power low after reset", {busy_drive, nv_op, acc_ready}, 0);
    pwr_low = 1'b0;
    op_run(2'd3, len);
    chk(len == RCL, "R1", "recall length", len, RCL);
    chk(acc_ready === 1'b1, "R1", "ready after recall", acc_ready, 1);
  endtask

  task automatic t_sw_clean();
    bit seen;
    pulse_sw();
    measure_store("R4", seen);
    chk(seen, "R4", "software store on clean flag", seen, 1);
    wait_idle();
  endtask

  task automatic t_hw_clean_and_block();
    int busy_seen = 0, op_seen = 0;
    @(negedge clk); ext_pull = 1'b1;
    cyc(3);
    acc_we = 1'b1; #0.5;
    chk(acc_ready === 1'b0, "R6", "write refused while line low", acc_ready, 0);
    acc_we = 1'b0; #0.5;
    chk(acc_ready === 1'b1, "R6", "read allowed while line low", acc_ready, 1);
    repeat (20) begin
      if (busy_drive) busy_seen++;
      if (nv_op != 2'd0) op_seen++;
      @(negedge clk);
    end
    chk(busy_seen == 0 && op_seen == 0, "R3", "clean line request dropped", busy_seen + op_seen, 0);
    ext_pull = 1'b0; cyc(3);
    acc_we = 1'b1; #0.5;
    chk(acc_ready === 1'b1, "R6", "write accepted after line high", acc_ready, 1);
    acc_we = 1'b0;
  endtask

  task automatic t_hw_dirty_hold();
    bit seen;
    int bad = 0;
    do_write();
    @(negedge clk); ext_pull = 1'b1;
    measure_store("R3", seen);
    chk(seen, "R3", "dirty line request stores", seen, 1);
    repeat (10) begin
      if (acc_ready || busy_drive) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9", "locked until line high", bad, 0);
    ext_pull = 1'b0;
    cyc(4);
    chk(acc_ready === 1'b1, "R9", "ready after line high", acc_ready, 1);
  endtask

  task automatic t_dirty_cleared();
    int busy_seen = 0;
    @(negedge clk); ext_pull = 1'b1;
    repeat (20) begin if (busy_drive) busy_seen++; @(negedge clk); end
    ext_pull = 1'b0; cyc(3);
    chk(busy_seen == 0, "R12", "flag cleared by store", busy_seen, 0);
  endtask

  task automatic t_auto_dirty();
    bit seen;
    int len;
    do_write();
    @(negedge clk); pwr_low = 1'b1;
    measure_store("R2", seen);
    chk(seen, "R2", "power loss stores dirty image", seen, 1);
    cyc(4);
    chk(acc_ready === 1'b0, "R2", "power off after store", acc_ready, 0);
    pwr_low = 1'b0;
    op_run(2'd3, len);
    chk(len == RCL, "R2", "recall after power return", len, RCL);
  endtask

  task automatic t_auto_clean();
    int busy_seen = 0, len;
    wait_idle();
    @(negedge clk); pwr_low = 1'b1;
    repeat (15) begin if (busy_drive) busy_seen++; @(negedge clk); end
    chk(busy_seen == 0, "R2", "clean power loss no store", busy_seen, 0);
    chk(acc_ready === 1'b0, "R2", "power off clean", acc_ready, 0);
    pwr_low = 1'b0;
    op_run(2'd3, len);
    chk(len == RCL, "R2", "recall after clean loss", len, RCL);
  endtask

  task automatic t_inhibit();
    int busy_seen = 0, len;
    bit seen;
    inhibit_auto = 1'b1;
    wait_idle();
    do_write();
    @(negedge clk); pwr_low = 1'b1;
    repeat (15) begin if (busy_drive) busy_seen++; @(negedge clk); end
    chk(busy_seen == 0, "R10", "inhibit blocks power-loss store", busy_seen, 0);
    pwr_low = 1'b0;
    op_run(2'd3, len);
    do_write();
    pulse_sw();
    measure_store("R10", seen);
    chk(seen, "R10", "software store under inhibit", seen, 1);
    wait_idle();
    do_write();
    @(negedge clk); ext_pull = 1'b1; cyc(3); ext_pull = 1'b0;
    measure_store("R10", seen);
    chk(seen, "R10", "line store under inhibit", seen, 1);
    wait_idle();
    inhibit_auto = 1'b0;
  endtask

  task automatic t_pwr_glitch_in_store();
    int len, w = 0;
    pulse_sw();
    while (nv_op != 2'd1 && w < 40) begin @(negedge clk); w++; end
    pwr_low = 1'b1; @(negedge clk); pwr_low = 1'b0;
    op_run(2'd3, len);
    chk(len == RCL, "R11", "recall after glitch in store", len, RCL);
    wait_idle();
  endtask

  task automatic t_concurrent();
    bit seen;
    int len;
    pulse_sw();
    measure_store("R4", seen);
    wait_idle();
    @(negedge clk); sw_store = 1'b1; pwr_low = 1'b1;
    @(negedge clk); sw_store = 1'b0;
    measure_store("R4", seen);
    chk(seen, "R4", "pulse with clean power loss stores", seen, 1);
    cyc(4);
    chk(acc_ready === 1'b0, "R11", "power off after concurrent store", acc_ready, 0);
    pwr_low = 1'b0;
    op_run(2'd3, len);
    chk(len == RCL, "R11", "recall after concurrent store", len, RCL);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_sw_clean();
    t_hw_clean_and_block();
    t_hw_dirty_hold();
    t_dirty_cleared();
    t_auto_dirty();
    t_auto_clean();
    t_inhibit();
    t_pwr_glitch_in_store();
    t_concurrent();
    cyc(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule